// File: doc/BRIEF.md
# Receive Frame Status Readout Gate

This block stands between a host read port and the head of a receive frame FIFO. It decides what each host read returns: a data byte taken from the FIFO, one byte of the four-byte status record that belongs to the frame just drained, or nothing. When nothing is returned, the data-valid strobe stays low and the read has no effect.

Once the last data byte of a frame has been read, the block locks out further data reads until the host has consumed that frame's four status bytes. The host reaches the status in one of two ways. In register mode it reads one dedicated status location four times. In direct mode the status bytes arrive as the next four reads on the ordinary data path.

After a FIFO overflow, the FIFO marks its head as the overflowed frame. The first read of that frame returns end-of-frame, raises the interrupt request unless it is masked, and acknowledges the overflow. A synthetic status record follows in which only the overflow flag is meaningful.

Top module: `rx_stat_gate`

## Requirements
- R1: After synchronous active-low reset, rd_valid, rd_eof and irq are 0 and no status lockout is pending, so a data read of a non-empty FIFO returns data.
- R2: A data read of a non-empty FIFO in either mode, with no lockout pending, pulses fifo_pop in the same cycle. In the next cycle it returns the head byte with rd_valid=1, and rd_eof equals the head's fifo_last flag.
- R3: After the last byte of a frame is read, data reads return rd_valid=0 and do not pop the FIFO until four status bytes have been read. Byte k (k = 0..3) is stat_word[8k+7:8k]. stat_ack pulses only with the fourth byte.
- R4: A read of the status location (rd_sel=1, register mode) returns rd_valid=0 and leaves the byte index unchanged when no status is pending, or when status is pending but stat_valid is 0.
- R5: In direct mode (mode_direct=1), the four reads that follow a frame's last byte return the status bytes on rd_data without popping the FIFO. The fifth read returns FIFO data again.
- R6: A data read with the FIFO empty, no overflow marker and no lockout returns rd_valid=0 and does not pop.
- R7: rx_req equals (fifo_count >= REQ_LEVEL) in every cycle, whether or not a status lockout is pending.
- R8: A data read with ovf_head=1 and no lockout returns rd_valid=1, rd_eof=1 and rd_data=0. It pulses ovf_ack, does not pop, and starts a status lockout.
- R9: The overflow end-of-frame read sets irq when irq_mask=0 and leaves it clear when irq_mask=1. irq stays set until an irq_clr pulse, and a set in the same cycle as a clear wins.
- R10: The status record after an overflow is 0x80, 0x00, 0x00, 0x00 (bit 7 of byte 0 is the overflow flag), whatever stat_word holds. It does not wait for stat_valid and does not pulse stat_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Host read strobe, one read per cycle high |
| rd_sel | input | 1 | Register mode target: 0 data location, 1 status location |
| mode_direct | input | 1 | 1 selects direct mode, where status arrives on the data path |
| rd_data | output | DW | Byte returned by the previous read |
| rd_valid | output | 1 | Previous read returned a valid byte |
| rd_eof | output | 1 | Returned byte ends a frame |
| fifo_data | input | DW | Byte at the FIFO head |
| fifo_last | input | 1 | Head byte is the last byte of its frame |
| fifo_empty | input | 1 | FIFO holds no data |
| fifo_count | input | CNT_W | FIFO fill level in bytes |
| ovf_head | input | 1 | Head of FIFO is an overflowed frame |
| fifo_pop | output | 1 | Remove the head byte at this edge |
| ovf_ack | output | 1 | Overflow end-of-frame has been delivered |
| rx_req | output | 1 | Receive data request, fill level at or above REQ_LEVEL |
| stat_word | input | DW*SB | Status record of the drained frame |
| stat_valid | input | 1 | stat_word is ready |
| stat_ack | output | 1 | Status record fully consumed |
| irq_mask | input | 1 | Masks the overflow interrupt |
| irq_clr | input | 1 | Host read of the interrupt flag, clears it |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the cycle-level invariants. The FIFO never pops while a lockout is pending or while it is empty. A nonzero byte index only exists with a lockout. stat_ack never fires for a synthetic overflow record. A valid strobe always follows a read, and irq rises only when unmasked. What these invariants cannot show is that the right bytes arrive in the right order. The directed scenarios cover that: byte ordering of the status record in both modes, resumption of data after exactly four status reads, the forced overflow record, masked and unmasked overflow interrupts, and the request output during a lockout.

// File: rtl/rsg_pkg.sv
// Package: shared types and constants for the receive status readout gate.
// Assumes status records are built from DW-bit bytes, byte 0 first.
package rsg_pkg;

    // Classification of one host read after arbitration.
    typedef enum logic [1:0] {
        RK_NONE = 2'd0,   // read ignored, no data-valid
        RK_DATA = 2'd1,   // FIFO data byte delivered
        RK_STAT = 2'd2,   // status record byte delivered
        RK_OVF  = 2'd3    // overflow end-of-frame delivered
    } rd_kind_e;

    // Bit of the status record that carries the overflow flag.
    localparam int OVF_FLAG_BIT = 7;

endpackage

// File: rtl/rsg_decode.sv
// Module: rsg_decode
// Purely combinational arbitration of a host read. It decides whether the
// read returns data, a status byte, the overflow end-of-frame, or nothing.
// Assumes ovf_head is only raised once the frames ahead of the overflowed
// frame have been drained from the FIFO.
module rsg_decode
    import rsg_pkg::*;
(
    input  logic     rd_en,
    input  logic     rd_sel,
    input  logic     mode_direct,
    input  logic     fifo_empty,
    input  logic     ovf_head,
    input  logic     stat_pend,
    input  logic     stat_ready,
    output rd_kind_e kind
);

    logic stat_target;

    // Status is reached through the data path in direct mode, else by location.
    always_comb stat_target = mode_direct | rd_sel;

    // Priority: lockout, then status-location misses, overflow marker, data.
    always_comb begin
        kind = RK_NONE;
        if (rd_en) begin
            if (stat_pend) begin
                if (stat_target && stat_ready) kind = RK_STAT;
            end else if (rd_sel && !mode_direct) begin
                kind = RK_NONE;
            end else if (ovf_head) begin
                kind = RK_OVF;
            end else if (!fifo_empty) begin
                kind = RK_DATA;
            end
        end
    end

endmodule

// File: rtl/rsg_status_seq.sv
// Module: rsg_status_seq
// Tracks the status lockout and the byte index into the status record.
// It selects between the supplied record and the synthetic overflow record.
// Assumes stat_word stays stable while stat_valid is high and a lockout is open.
module rsg_status_seq
    import rsg_pkg::*;
#(
    parameter int DW = 8,
    parameter int SB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rd_kind_e         kind,
    input  logic             fifo_last,
    input  logic [DW*SB-1:0] stat_word,
    input  logic             stat_valid,
    output logic             stat_pend,
    output logic             stat_ready,
    output logic [DW-1:0]    stat_byte,
    output logic             stat_ack
);

    localparam int IDX_W = (SB > 1) ? $clog2(SB) : 1;
    localparam int REC_W = DW * SB;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SB - 1);
    localparam logic [REC_W-1:0] OVF_REC  = REC_W'(1) << OVF_FLAG_BIT;

    logic [IDX_W-1:0] idx_q;
    logic             ovf_rec_q;
    logic [REC_W-1:0] rec;

    // Open, advance and close the lockout and its byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_pend <= 1'b0;
            idx_q     <= '0;
            ovf_rec_q <= 1'b0;
        end else begin
            case (kind)
                RK_DATA: if (fifo_last) begin
                    stat_pend <= 1'b1;
                    ovf_rec_q <= 1'b0;
                end
                RK_OVF: begin
                    stat_pend <= 1'b1;
                    ovf_rec_q <= 1'b1;
                end
                RK_STAT: begin
                    if (idx_q == LAST_IDX) begin
                        idx_q     <= '0;
                        stat_pend <= 1'b0;
                        ovf_rec_q <= 1'b0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Pick the record in force and the byte the index points at.
    always_comb begin
        rec        = ovf_rec_q ? OVF_REC : stat_word;
        stat_byte  = rec[int'(idx_q)*DW +: DW];
        stat_ready = stat_pend & (ovf_rec_q | stat_valid);
        stat_ack   = (kind == RK_STAT) && (idx_q == LAST_IDX) && !ovf_rec_q;
    end

    // R3: a nonzero byte index exists only inside a lockout
    a_r3_idx_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != '0) |-> stat_pend);

    // R3: the record acknowledge only happens inside a lockout
    a_r3_ack_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
        stat_ack |-> stat_pend);

    // R10: a synthetic overflow record is never acknowledged to the status source
    a_r10_ovf_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_rec_q |-> !stat_ack);

endmodule

// File: rtl/rsg_irq.sv
// Module: rsg_irq
// Interrupt flag raised by an unmasked overflow end-of-frame and cleared by
// the host's read of the flag. Assumes irq_clr is a one-cycle pulse.
module rsg_irq
    import rsg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rd_kind_e kind,
    input  logic     irq_mask,
    input  logic     irq_clr,
    output logic     irq
);

    logic set_evt;

    // Set request from an unmasked overflow end-of-frame read.
    always_comb set_evt = (kind == RK_OVF) && !irq_mask;

    // Hold the flag; a set in the same cycle as a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (set_evt) irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

    // R9: irq only rises after an unmasked overflow read
    a_r9_rise_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(kind) == RK_OVF && !$past(irq_mask)));

endmodule

// File: rtl/rx_stat_gate.sv
// Module: rx_stat_gate (top)
// Gates host reads of a receive FIFO and its per-frame status record, and
// registers the returned byte, data-valid and end-of-frame. Pops and
// acknowledges leave combinationally so the FIFO updates at the read's edge.
// Assumes one read per cycle at most and a FIFO that pops on fifo_pop.
module rx_stat_gate
    import rsg_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SB        = 4,
    parameter int CNT_W     = 7,
    parameter int REQ_LEVEL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             rd_sel,
    input  logic             mode_direct,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             rd_eof,
    input  logic [DW-1:0]    fifo_data,
    input  logic             fifo_last,
    input  logic             fifo_empty,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             ovf_head,
    output logic             fifo_pop,
    output logic             ovf_ack,
    output logic             rx_req,
    input  logic [DW*SB-1:0] stat_word,
    input  logic             stat_valid,
    output logic             stat_ack,
    input  logic             irq_mask,
    input  logic             irq_clr,
    output logic             irq
);

    localparam logic [CNT_W-1:0] REQ_CNT = CNT_W'(REQ_LEVEL);

    rd_kind_e        kind;
    logic            stat_pend;
    logic            stat_ready;
    logic [DW-1:0]   stat_byte;

    rsg_decode u_dec (
        .rd_en       (rd_en),
        .rd_sel      (rd_sel),
        .mode_direct (mode_direct),
        .fifo_empty  (fifo_empty),
        .ovf_head    (ovf_head),
        .stat_pend   (stat_pend),
        .stat_ready  (stat_ready),
        .kind        (kind)
    );

    rsg_status_seq #(.DW(DW), .SB(SB)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .fifo_last  (fifo_last),
        .stat_word  (stat_word),
        .stat_valid (stat_valid),
        .stat_pend  (stat_pend),
        .stat_ready (stat_ready),
        .stat_byte  (stat_byte),
        .stat_ack   (stat_ack)
    );

    rsg_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .irq_mask (irq_mask),
        .irq_clr  (irq_clr),
        .irq      (irq)
    );

    // FIFO-side strobes and the fill-level request, independent of lockout.
    always_comb begin
        fifo_pop = (kind == RK_DATA);
        ovf_ack  = (kind == RK_OVF);
        rx_req   = (fifo_count >= REQ_CNT);
    end

    // Register the result of this cycle's read for the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_eof   <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (kind != RK_NONE);
            rd_eof   <= ((kind == RK_DATA) && fifo_last) || (kind == RK_OVF);
            case (kind)
                RK_DATA: rd_data <= fifo_data;
                RK_STAT: rd_data <= stat_byte;
                default: rd_data <= '0;
            endcase
        end
    end

    // R3: the FIFO is never popped while a status lockout is pending
    a_r3_no_pop_locked: assert property (@(posedge clk) disable iff (!rst_n)
        stat_pend |-> !fifo_pop);

    // R6: the FIFO is never popped while empty
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R2: data-valid only follows a read strobe
    a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en));

    // R8: the overflow acknowledge never coincides with a pop
    a_r8_ack_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ack |-> !fifo_pop);

endmodule

// File: tb/rx_stat_gate_tb_top.sv
module rx_stat_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_en, rd_sel, mode_direct;
    logic [7:0]  rd_data;
    logic        rd_valid, rd_eof;
    logic [7:0]  fifo_data;
    logic        fifo_last, fifo_empty;
    logic [6:0]  fifo_count;
    logic        ovf_head, fifo_pop, ovf_ack, rx_req;
    logic [31:0] stat_word;
    logic        stat_valid, stat_ack;
    logic        irq_mask, irq_clr, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // FIFO model
    logic [7:0] qd [64];
    logic       ql [64];
    int hd = 0;
    int tl = 0;

    always #10 clk = ~clk;

    assign fifo_empty = (hd == tl);
    assign fifo_data  = qd[hd % 64];
    assign fifo_last  = ql[hd % 64];
    assign fifo_count = 7'(tl - hd);

    always @(posedge clk) if (fifo_pop) hd <= hd + 1;

    rx_stat_gate dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel),
        .mode_direct(mode_direct), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_eof(rd_eof), .fifo_data(fifo_data), .fifo_last(fifo_last),
        .fifo_empty(fifo_empty), .fifo_count(fifo_count), .ovf_head(ovf_head),
        .fifo_pop(fifo_pop), .ovf_ack(ovf_ack), .rx_req(rx_req),
        .stat_word(stat_word), .stat_valid(stat_valid), .stat_ack(stat_ack),
        .irq_mask(irq_mask), .irq_clr(irq_clr), .irq(irq)
    );

    // sampled results of the last read
    logic s_pop, s_ack, s_oack, s_v, s_e;
    logic [7:0] s_d;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic last);
        qd[tl % 64] = d;
        ql[tl % 64] = last;
        tl = tl + 1;
    endtask

    // one host read; called at a negedge, returns at the next negedge
    task automatic do_read(input logic sel);
        rd_en  = 1'b1;
        rd_sel = sel;
        #1;
        s_pop  = fifo_pop;
        s_ack  = stat_ack;
        s_oack = ovf_ack;
        @(negedge clk);
        rd_en = 1'b0;
        s_v = rd_valid;
        s_d = rd_data;
        s_e = rd_eof;
    endtask

    task automatic t_reset;
        chk(rd_valid == 1'b0, "R1", "rd_valid after reset", 32'(rd_valid), 0);
        chk(irq == 1'b0, "R1", "irq after reset", 32'(irq), 0);
        chk(rd_eof == 1'b0, "R1", "rd_eof after reset", 32'(rd_eof), 0);
        chk(rx_req == 1'b0, "R7", "rx_req empty fifo", 32'(rx_req), 0);
    endtask

    task automatic t_empty;
        mode_direct = 1'b0;
        do_read(1'b0);
        chk(!s_v && !s_pop, "R6", "empty read valid/pop", {s_v, s_pop}, 0);
        do_read(1'b1);
        chk(!s_v, "R4", "status read, none pending", 32'(s_v), 0);
    endtask

    task automatic t_register_mode;
        mode_direct = 1'b0;
        stat_valid  = 1'b0;
        push(8'hA1, 0); push(8'hA2, 0); push(8'hA3, 1);
        do_read(1'b0);
        chk(s_pop && s_v && s_d == 8'hA1 && !s_e, "R1", "first data after reset", 32'(s_d), 32'hA1);
        do_read(1'b0);
        chk(s_v && s_d == 8'hA2 && !s_e, "R2", "second data byte", 32'(s_d), 32'hA2);
        do_read(1'b0);
        chk(s_v && s_d == 8'hA3 && s_e, "R2", "last byte with eof", {s_e, s_d}, 32'h1A3);
        push(8'hB1, 0); push(8'hB2, 0); push(8'hB3, 0); push(8'hB4, 1);
        #1;
        chk(rx_req == 1'b1, "R7", "rx_req during lockout", 32'(rx_req), 1);
        do_read(1'b1);
        chk(!s_v, "R4", "status read, not ready", 32'(s_v), 0);
        do_read(1'b0);
        chk(!s_v && !s_pop, "R3", "locked data read", {s_v, s_pop}, 0);
        stat_word  = 32'h44332211;
        stat_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            do_read(1'b1);
            chk(s_v && s_d == 8'(8'h11 * (k + 1)), "R3", "status byte order", 32'(s_d), 32'(8'h11 * (k + 1)));
            chk(s_ack == (k == 3), "R3", "stat_ack timing", 32'(s_ack), 32'(k == 3));
            chk(!s_pop, "R3", "no pop on status", 32'(s_pop), 0);
        end
        stat_valid = 1'b0;
        do_read(1'b0);
        chk(s_v && s_d == 8'hB1, "R3", "data resumes after status", 32'(s_d), 32'hB1);
        for (int k = 0; k < 3; k++) do_read(1'b0);
        chk(s_e && s_d == 8'hB4, "R2", "frame B end", {s_e, s_d}, 32'h1B4);
        stat_word  = 32'h08070605;
        stat_valid = 1'b1;
        for (int k = 0; k < 4; k++) do_read(1'b1);
        stat_valid = 1'b0;
    endtask

    task automatic t_direct_mode;
        mode_direct = 1'b1;
        push(8'hC1, 0); push(8'hC2, 1); push(8'hD1, 0);
        do_read(1'b0);
        do_read(1'b0);
        chk(s_e && s_d == 8'hC2, "R5", "direct last byte", {s_e, s_d}, 32'h1C2);
        stat_word  = 32'hDDCCBBAA;
        stat_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            do_read(1'b0);
            chk(s_v && !s_pop && s_d == 8'(8'hAA + 8'h11 * k), "R5", "direct status byte",
                32'(s_d), 32'(8'hAA + 8'h11 * k));
        end
        stat_valid = 1'b0;
        do_read(1'b0);
        chk(s_v && s_pop && s_d == 8'hD1, "R5", "direct data resumes", 32'(s_d), 32'hD1);
        mode_direct = 1'b0;
    endtask

    task automatic t_overflow;
        mode_direct = 1'b0;
        irq_mask    = 1'b0;
        stat_word   = 32'hFFFFFFFF;
        stat_valid  = 1'b0;
        ovf_head    = 1'b1;
        do_read(1'b0);
        chk(s_v && s_e && s_d == 8'h00, "R8", "overflow eof read", {s_v, s_e, s_d}, 32'h300);
        chk(s_oack && !s_pop, "R8", "ovf_ack without pop", {s_oack, s_pop}, 32'h2);
        ovf_head = 1'b0;
        chk(irq == 1'b1, "R9", "irq after unmasked overflow", 32'(irq), 1);
        push(8'hE1, 1);
        do_read(1'b0);
        chk(!s_v && !s_pop, "R8", "lockout after overflow", {s_v, s_pop}, 0);
        for (int k = 0; k < 4; k++) begin
            do_read(1'b1);
            chk(s_v && s_d == ((k == 0) ? 8'h80 : 8'h00), "R10", "overflow record byte",
                32'(s_d), (k == 0) ? 32'h80 : 0);
            chk(!s_ack, "R10", "no stat_ack for overflow record", 32'(s_ack), 0);
        end
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq == 1'b0, "R9", "irq cleared by host", 32'(irq), 0);
        do_read(1'b0);
        chk(s_v && s_d == 8'hE1, "R8", "data after overflow record", 32'(s_d), 32'hE1);
        stat_word = 32'h0; stat_valid = 1'b1;
        for (int k = 0; k < 4; k++) do_read(1'b1);
        stat_valid = 1'b0;
        // masked overflow, with a clear pulse in the same cycle
        irq_mask = 1'b1;
        ovf_head = 1'b1;
        do_read(1'b0);
        ovf_head = 1'b0;
        chk(s_e && irq == 1'b0, "R9", "masked overflow leaves irq low", 32'(irq), 0);
        for (int k = 0; k < 4; k++) do_read(1'b1);
        irq_mask = 1'b0;
        ovf_head = 1'b1;
        irq_clr  = 1'b1;
        do_read(1'b0);
        irq_clr  = 1'b0;
        ovf_head = 1'b0;
        chk(irq == 1'b1, "R9", "set wins over clear", 32'(irq), 1);
        for (int k = 0; k < 4; k++) do_read(1'b1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; rd_en = 1'b0; rd_sel = 1'b0; mode_direct = 1'b0;
        ovf_head = 1'b0; stat_word = '0; stat_valid = 1'b0;
        irq_mask = 1'b0; irq_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_register_mode();
        t_empty();
        t_direct_mode();
        t_overflow();
        finish_run();
    end

endmodule